// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block maps a 32-bit virtual word address to a physical word address in two steps. A segment table, indexed by a field of the upper address bits, gives a short page-group number. That number, joined with six middle address bits, selects one page descriptor. The descriptor supplies a page frame, a space type and its permission bits. The frame is placed above the ten low offset bits to form the physical word address. Translation is purely combinational, so a requester presents an address and reads the result in the same cycle.

Software reaches both tables and two fault status words through a register port. That port has byte enables, read data that appears one cycle after the request, and writes that take effect at the next clock edge. When a translation request fails, the block flags an error in the same cycle and records the cause and the faulting byte address. Reading a status word returns it and then clears it.

Top module: `segpage_xlat`

## Requirements
- R1: The segment index is word-address bits [16+SEG_IDX_W-1:16]. The page index is {segment entry, address bits [15:10]}. `xl_paddr` is {descriptor bits [15:0], address bits [9:0]}, zero-extended, and `xl_space` is descriptor bits [27:26]. The descriptor bits are: 31 valid, 30 writable, 29 supervisor-only.
- R2: A segment write (`map_sel`=0) stores the byte selected by the enables: bits [7:0] for `map_be`=4'b1111, bits [23:16] for 4'b1100 and bits [31:24] for 4'b1000.
- R3: A segment write with any other enable pattern stores zero. A segment read with any other pattern returns zero.
- R4: A segment read returns the entry in the lane the enables select: at bit 0 for 4'b1111, at bit 16 for 4'b1100 and at bit 24 for 4'b1000.
- R5: A page-descriptor write (`map_sel`=1), addressed like a translation, replaces only the bytes whose enable is set. Enable bit k covers data bits [8k+7:8k].
- R6: A request through a descriptor whose valid bit is clear raises `xl_err`. It ORs 0x80 into status word 0 (`map_sel`=2) and sets bit 15 for a write or clears it for a read. It stores the byte address (word address × 4) in status word 1 (`map_sel`=3).
- R7: A write to a valid page that is not writable, or a user-mode write to a supervisor-only page, raises `xl_err`. It ORs 0x8040 into status word 0 and stores the byte address in status word 1. Reads never cause this fault.
- R8: A request to a valid, permitted page of space type 2 or 3 raises `xl_err`. It overwrites status word 0 with 0x20 for a read or 0x8020 for a write, and stores the byte address in status word 1.
- R9: Reading a status word returns its current value and leaves it zero afterwards.
- R10: A request that does not fault keeps `xl_err` low and leaves both status words unchanged.
- R11: After reset both status words and `map_rdata` are zero, and every table entry is zero, so every descriptor is invalid.
- R12: Read data appears on `map_rdata` in the cycle after `map_rd`, and a table write is visible to reads and translations from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| map_wr | input | 1 | Register-port write strobe |
| map_rd | input | 1 | Register-port read strobe |
| map_sel | input | 2 | Target: 0 segment, 1 page, 2 status 0, 3 status 1 |
| map_addr | input | 32 | Word address that selects the table entry |
| map_be | input | 4 | Byte enables |
| map_wdata | input | 32 | Write data |
| map_rdata | output | 32 | Read data, registered |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | Virtual word address |
| xl_write | input | 1 | Request is a write |
| xl_super | input | 1 | Request is in supervisor mode |
| xl_paddr | output | 32 | Physical word address |
| xl_space | output | 2 | Space type of the page |
| xl_err | output | 1 | Translation fault this cycle |

## Verification
The hardest situations to reach are those where the status word builds up over several faults: an OR-merge on top of earlier bits, or a space-type fault that overwrites them. Reaching them needs a valid segment entry, then page descriptors with chosen permission bits, and then a series of faulting requests with no status read in between. The stimulus first programs one segment with descriptors for each case. It then issues an invalid write followed by an invalid read, so bit 15 has to clear. It issues another invalid write followed by a bad-space read, so the earlier bits have to vanish. Only after that does it read the status words back.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
    typedef enum logic [1:0] {LANE_NONE, LANE_FULL, LANE_HALF_HI, LANE_BYTE_HI} lane_e;
    typedef enum logic [1:0] {FLT_NONE, FLT_INVALID, FLT_PROTECT, FLT_SPACE} fault_e;

    localparam int unsigned VALID_BIT = 31;
    localparam int unsigned WRITE_BIT = 30;
    localparam int unsigned SUPER_BIT = 29;
    localparam int unsigned TYPE_LSB  = 26;
    localparam int unsigned FRAME_W   = 16;
    localparam int unsigned OFFSET_W  = 10;
    localparam int unsigned PAGE_BITS = 6;
    localparam int unsigned SEG_LSB   = 16;

    typedef struct packed {
        logic [31:0] s0;
        logic [31:0] s1;
    } stat_t;

    function automatic lane_e lane_decode(input logic [3:0] be);
        case (be)
            4'b1111: return LANE_FULL;
            4'b1100: return LANE_HALF_HI;
            4'b1000: return LANE_BYTE_HI;
            default: return LANE_NONE;
        endcase
    endfunction

    function automatic logic [7:0] lane_pick(input lane_e k, input logic [31:0] d);
        case (k)
            LANE_FULL:    return d[7:0];
            LANE_HALF_HI: return d[23:16];
            LANE_BYTE_HI: return d[31:24];
            default:      return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] lane_place(input lane_e k, input logic [7:0] v);
        case (k)
            LANE_FULL:    return {24'h0, v};
            LANE_HALF_HI: return {8'h0, v, 16'h0};
            LANE_BYTE_HI: return {v, 24'h0};
            default:      return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/segpage_segmap.sv
module segpage_segmap
    import segpage_pkg::*;
#(
    parameter int unsigned SEG_IDX_W = 8,
    parameter int unsigned PMEG_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_IDX_W-1:0] wr_idx,
    input  lane_e                wr_lane,
    input  logic [31:0]          wr_data,
    input  logic [SEG_IDX_W-1:0] rd_idx_a,
    output logic [PMEG_W-1:0]    rd_data_a,
    input  logic [SEG_IDX_W-1:0] rd_idx_b,
    output logic [PMEG_W-1:0]    rd_data_b
);
    localparam int unsigned SEG_N = 1 << SEG_IDX_W;

    logic [PMEG_W-1:0] seg_q [SEG_N];
    logic [PMEG_W-1:0] wr_val_d;

    always_comb begin
        wr_val_d = PMEG_W'(lane_pick(wr_lane, wr_data));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_N; i++) seg_q[i] <= '0;
        end else if (wr_en) begin
            seg_q[wr_idx] <= wr_val_d;
        end
    end

    assign rd_data_a = seg_q[rd_idx_a];
    assign rd_data_b = seg_q[rd_idx_b];

    // an unrecognised lane pattern stores zero
    p_unknown_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lane == LANE_NONE) |=> (seg_q[$past(wr_idx)] == '0));
endmodule

// File: rtl/segpage_pagemap.sv
module segpage_pagemap #(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [3:0]       wr_be,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [31:0]      rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [31:0]      rd_data_b
);
    localparam int unsigned PAGE_N = 1 << IDX_W;

    logic [31:0] page_q [PAGE_N];
    logic [31:0] merged_d;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        always_comb begin
            merged_d[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : page_q[wr_idx][8*b +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_N; i++) page_q[i] <= '0;
        end else if (wr_en) begin
            page_q[wr_idx] <= merged_d;
        end
    end

    assign rd_data_a = page_q[rd_idx_a];
    assign rd_data_b = page_q[rd_idx_b];

    // a disabled lane keeps its old byte
    p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[0]) |=> (page_q[$past(wr_idx)][7:0] == $past(page_q[wr_idx][7:0])));
endmodule

// File: rtl/segpage_fault.sv
module segpage_fault
    import segpage_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  fault_e      flt,
    input  logic        is_write,
    input  logic [31:0] byte_addr,
    input  logic        clr0,
    input  logic        clr1,
    output logic [31:0] stat0,
    output logic [31:0] stat1
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr0) st_d.s0 = '0;
        if (clr1) st_d.s1 = '0;
        case (flt)
            FLT_INVALID: begin
                st_d.s0 = is_write ? (st_d.s0 | 32'h8080) : ((st_d.s0 | 32'h0080) & ~32'h8000);
                st_d.s1 = byte_addr;
            end
            FLT_PROTECT: begin
                st_d.s0 = st_d.s0 | 32'h8040;
                st_d.s1 = byte_addr;
            end
            FLT_SPACE: begin
                st_d.s0 = is_write ? 32'h8020 : 32'h0020;
                st_d.s1 = byte_addr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat0 = st_q.s0;
    assign stat1 = st_q.s1;

    p_invalid_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt == FLT_INVALID) |=> (stat0[7] && stat0[15] == $past(is_write) && stat1 == $past(byte_addr)));
    p_protect_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt == FLT_PROTECT) |=> (stat0[15] && stat0[6] && stat1 == $past(byte_addr)));
    p_space_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt == FLT_SPACE) |=> (stat0 == ($past(is_write) ? 32'h8020 : 32'h0020)));
    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && flt == FLT_NONE) |=> (stat0 == '0));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt == FLT_NONE && !clr0) |=> $stable(stat0));
endmodule

// File: rtl/segpage_xlat.sv
module segpage_xlat
    import segpage_pkg::*;
#(
    parameter int unsigned SEG_IDX_W = 8,
    parameter int unsigned PMEG_W    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        map_wr,
    input  logic        map_rd,
    input  logic [1:0]  map_sel,
    input  logic [31:0] map_addr,
    input  logic [3:0]  map_be,
    input  logic [31:0] map_wdata,
    output logic [31:0] map_rdata,
    input  logic        xl_req,
    input  logic [31:0] xl_addr,
    input  logic        xl_write,
    input  logic        xl_super,
    output logic [31:0] xl_paddr,
    output logic [1:0]  xl_space,
    output logic        xl_err
);
    localparam int unsigned PIDX_W = PMEG_W + PAGE_BITS;
    localparam int unsigned PA_W   = FRAME_W + OFFSET_W;
    localparam logic [1:0]  SEL_SEG = 2'd0, SEL_PAGE = 2'd1, SEL_ST0 = 2'd2, SEL_ST1 = 2'd3;

    logic [SEG_IDX_W-1:0] seg_idx_xl, seg_idx_map;
    logic [PMEG_W-1:0]    seg_xl, seg_map;
    logic [PIDX_W-1:0]    pidx_xl, pidx_map;
    logic [31:0]          pte_xl, pte_map;
    logic [31:0]          stat0, stat1;
    lane_e                lane;
    fault_e               flt;
    logic [31:0]          rdata_d, rdata_q;

    assign seg_idx_xl  = xl_addr[SEG_LSB +: SEG_IDX_W];
    assign seg_idx_map = map_addr[SEG_LSB +: SEG_IDX_W];
    assign pidx_xl     = {seg_xl, xl_addr[OFFSET_W +: PAGE_BITS]};
    assign pidx_map    = {seg_map, map_addr[OFFSET_W +: PAGE_BITS]};
    assign lane        = lane_decode(map_be);

    segpage_segmap #(.SEG_IDX_W(SEG_IDX_W), .PMEG_W(PMEG_W)) seg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_wr && map_sel == SEL_SEG), .wr_idx(seg_idx_map),
        .wr_lane(lane), .wr_data(map_wdata),
        .rd_idx_a(seg_idx_xl), .rd_data_a(seg_xl),
        .rd_idx_b(seg_idx_map), .rd_data_b(seg_map)
    );

    segpage_pagemap #(.IDX_W(PIDX_W)) page_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_wr && map_sel == SEL_PAGE), .wr_idx(pidx_map),
        .wr_be(map_be), .wr_data(map_wdata),
        .rd_idx_a(pidx_xl), .rd_data_a(pte_xl),
        .rd_idx_b(pidx_map), .rd_data_b(pte_map)
    );

    // fault priority: invalid, then protection, then space type
    always_comb begin
        flt = FLT_NONE;
        if (xl_req) begin
            if (!pte_xl[VALID_BIT])
                flt = FLT_INVALID;
            else if (xl_write && (!pte_xl[WRITE_BIT] || (pte_xl[SUPER_BIT] && !xl_super)))
                flt = FLT_PROTECT;
            else if (pte_xl[TYPE_LSB+1])
                flt = FLT_SPACE;
        end
    end

    segpage_fault fault_i (
        .clk(clk), .rst_n(rst_n), .flt(flt), .is_write(xl_write),
        .byte_addr({xl_addr[29:0], 2'b00}),
        .clr0(map_rd && map_sel == SEL_ST0), .clr1(map_rd && map_sel == SEL_ST1),
        .stat0(stat0), .stat1(stat1)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (map_rd) begin
            case (map_sel)
                SEL_SEG:  rdata_d = lane_place(lane, 8'(seg_map));
                SEL_PAGE: rdata_d = pte_map;
                SEL_ST0:  rdata_d = stat0;
                default:  rdata_d = stat1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign map_rdata = rdata_q;
    assign xl_err    = (flt != FLT_NONE);
    assign xl_space  = pte_xl[TYPE_LSB +: 2];
    assign xl_paddr  = {{(32-PA_W){1'b0}}, pte_xl[FRAME_W-1:0], xl_addr[OFFSET_W-1:0]};

    logic unused_bits;
    assign unused_bits = ^{xl_addr[31:30], map_addr[31:SEG_LSB+SEG_IDX_W],
                           map_addr[OFFSET_W-1:0], pte_xl[28], pte_xl[25:FRAME_W]};

    p_rdata_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (map_rd && map_sel == SEL_ST0) |=> (map_rdata == $past(stat0)));
endmodule

// File: tb/segpage_xlat_tb_top.sv
module segpage_xlat_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        map_wr = 0, map_rd = 0;
    logic [1:0]  map_sel = 0;
    logic [31:0] map_addr = 0, map_wdata = 0;
    logic [3:0]  map_be = 0;
    logic [31:0] map_rdata;
    logic        xl_req = 0, xl_write = 0, xl_super = 0;
    logic [31:0] xl_addr = 0;
    logic [31:0] xl_paddr;
    logic [1:0]  xl_space;
    logic        xl_err;

    segpage_xlat dut_i (
        .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .map_rd(map_rd), .map_sel(map_sel),
        .map_addr(map_addr), .map_be(map_be), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .xl_req(xl_req), .xl_addr(xl_addr), .xl_write(xl_write), .xl_super(xl_super),
        .xl_paddr(xl_paddr), .xl_space(xl_space), .xl_err(xl_err)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic pend = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: one registered result per read strobe
    always @(posedge clk) pend <= map_rd;
    always @(negedge clk) begin
        exp_t e;
        if (pend) begin
            if (exp_q.size() == 0) chk("R12 unexpected read data", map_rdata, 32'hx);
            else begin
                e = exp_q.pop_front();
                chk(e.tag, map_rdata, e.val);
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        map_wr = 1; map_sel = sel; map_addr = a; map_be = be; map_wdata = d;
        @(negedge clk);
        map_wr = 0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        map_rd = 1; map_sel = sel; map_addr = a; map_be = be;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        map_rd = 0;
    endtask

    task automatic xl(input logic [31:0] a, input logic w, input logic s, input logic exp_err,
                      input logic [31:0] exp_pa, input logic [1:0] exp_sp, input string tag);
        @(negedge clk);
        xl_req = 1; xl_addr = a; xl_write = w; xl_super = s;
        #1;
        chk({tag, " err"}, {31'h0, xl_err}, {31'h0, exp_err});
        if (!exp_err) begin
            chk({tag, " paddr"}, xl_paddr, exp_pa);
            chk({tag, " space"}, {30'h0, xl_space}, {30'h0, exp_sp});
        end
        @(negedge clk);
        xl_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        rd(2, 0, 4'hF, 32'h0, "R11 status0 after reset");
        rd(3, 0, 4'hF, 32'h0, "R11 status1 after reset");
        rd(1, 32'h0012_0C00, 4'hF, 32'h0, "R11 descriptor after reset");
        // R2 / R4 segment lanes (sel 0)
        wr(0, 32'h0012_0000, 4'b1111, 32'hAAAA_AA05);
        rd(0, 32'h0012_0000, 4'b1111, 32'h0000_0005, "R4 full lane");
        rd(0, 32'h0012_0000, 4'b1100, 32'h0005_0000, "R4 half lane");
        rd(0, 32'h0012_0000, 4'b1000, 32'h0500_0000, "R4 byte lane");
        wr(0, 32'h0013_0000, 4'b1100, 32'h1107_2233);
        rd(0, 32'h0013_0000, 4'b1111, 32'h7, "R2 write bits 23:16");
        wr(0, 32'h0014_0000, 4'b1000, 32'h0911_2233);
        rd(0, 32'h0014_0000, 4'b1111, 32'h9, "R2 write bits 31:24");
        // R3 unknown pattern
        wr(0, 32'h0012_0000, 4'b0011, 32'hFFFF_FFFF);
        rd(0, 32'h0012_0000, 4'b1111, 32'h0, "R3 odd mask write stores zero");
        rd(0, 32'h0013_0000, 4'b0011, 32'h0, "R3 odd mask read zero");
        wr(0, 32'h0012_0000, 4'b1111, 32'h5);
        // R5 descriptor merge
        wr(1, 32'h0012_0C00, 4'hF, 32'hC000_1234);
        rd(1, 32'h0012_0C00, 4'hF, 32'hC000_1234, "R12 descriptor write visible");
        wr(1, 32'h0012_0C00, 4'b0001, 32'h5566_77AB);
        rd(1, 32'h0012_0C00, 4'hF, 32'hC000_12AB, "R5 single lane merge");
        wr(1, 32'h0012_0C00, 4'b0110, 32'hFF00_0000);
        rd(1, 32'h0012_0C00, 4'hF, 32'hC000_00AB, "R5 middle lanes merge");
        wr(1, 32'h0012_0C00, 4'b0010, 32'h0000_1200);
        // R1 translation
        xl(32'h0012_0D55, 1, 0, 0, {6'h0, 16'h12AB, 10'h155}, 2'd0, "R1 user write type0");
        wr(1, 32'h0013_0000, 4'hF, 32'hC400_00FF);
        xl(32'h0013_03FF, 0, 0, 0, 32'h0003_FFFF, 2'd1, "R1 second segment type1");
        rd(2, 0, 4'hF, 32'h0, "R10 no status after good requests");
        // R6 invalid descriptor
        xl(32'h0012_1000, 1, 1, 1, 0, 0, "R6 invalid write");
        xl(32'h0012_1000, 0, 1, 1, 0, 0, "R6 invalid read");
        rd(2, 0, 4'hF, 32'h0000_0080, "R6 read clears bit 15");
        rd(3, 0, 4'hF, 32'h0048_4000, "R6 byte address");
        rd(2, 0, 4'hF, 32'h0, "R9 status0 cleared");
        rd(3, 0, 4'hF, 32'h0, "R9 status1 cleared");
        xl(32'h0012_1000, 1, 0, 1, 0, 0, "R6 invalid write alone");
        rd(2, 0, 4'hF, 32'h0000_8080, "R6 write code");
        // R7 protection
        wr(1, 32'h0012_1400, 4'hF, 32'h8000_0001);
        xl(32'h0012_1400, 0, 0, 0, 32'h0000_0400, 2'd0, "R7 read of readonly ok");
        xl(32'h0012_1400, 1, 1, 1, 0, 0, "R7 write to readonly");
        rd(2, 0, 4'hF, 32'h0000_8040, "R7 readonly code");
        rd(3, 0, 4'hF, 32'h0048_5000, "R7 readonly address");
        wr(1, 32'h0012_1800, 4'hF, 32'hE000_0002);
        xl(32'h0012_1800, 1, 1, 0, 32'h0000_0800, 2'd0, "R7 supervisor write ok");
        xl(32'h0012_1800, 1, 0, 1, 0, 0, "R7 user write to super page");
        rd(3, 0, 4'hF, 32'h0048_6000, "R7 super page address");
        rd(2, 0, 4'hF, 32'h0000_8040, "R7 super page code");
        // R8 space types
        wr(1, 32'h0012_1C00, 4'hF, 32'hC800_0003);
        xl(32'h0012_1000, 1, 0, 1, 0, 0, "R8 setup invalid write");
        xl(32'h0012_1C00, 0, 0, 1, 0, 0, "R8 bad space read");
        rd(2, 0, 4'hF, 32'h0000_0020, "R8 read code overwrites");
        wr(1, 32'h0012_2000, 4'hF, 32'hCC00_0004);
        xl(32'h0012_2000, 1, 1, 1, 0, 0, "R8 type3 write");
        rd(2, 0, 4'hF, 32'h0000_8020, "R8 write code");
        rd(3, 0, 4'hF, 32'h0048_8000, "R8 address");
        @(negedge clk);
        @(negedge clk);
        chk("R12 all reads answered", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule